// File: doc/BRIEF.md
# Offset-Addressed Multi-Bit Trie Lookup Engine

This block finds the longest matching prefix of a destination address by walking a compact multi-bit trie stored in a local node memory. A node word holds only two fields. The first is a per-index bitmap of 2^STRIDE terminate flags. The second is a small offset. Nodes carry no child pointers and no result pointers. When a walk reaches a node, the address of the next node is computed as the current node address, plus the stored offset, plus the number of zero flags below the selected index. This works because the only nodes stored are the non-leaf nodes, and they are numbered level by level from left to right, starting at address 1.

A lookup starts with a one-cycle `start` pulse that carries `addrIn`. The engine consumes STRIDE address bits per node, starting with the most significant bits. It stops when the selected flag is 1. It then returns the consumed address bits, left-aligned, together with their count. The caller uses this as the key into an external next-hop table. The engine also reports when the address runs out without any flag being hit. It reports an error when a computed child address lies above the highest node address written so far. Node words are loaded through a one-word write port while the engine is idle.

Top module: `oet_lookup`

## Requirements
- R1: After reset, `busy`, `done`, `matchOut`, `noMatch`, `errOut`, `keyOut` and `lenOut` are all zero, and the highest written node address is 0.
- R2: A node word is `{offset[OFF_W-1:0], flags[2^STRIDE-1:0]}`, where flag bit i belongs to index value i. The index at each level is the next STRIDE address bits, taken starting at the most significant end. The walk begins at node address 1.
- R3: When the selected flag is 1, the walk ends with `matchOut`=1. `lenOut` is STRIDE times the number of nodes visited, and `keyOut` is `addrIn` with every bit below the top `lenOut` bits cleared.
- R4: When the selected flag is 0, the next node address is the current address plus the offset plus the count of zero flags at positions below the index.
- R5: If a walk visits ADDR_W/STRIDE nodes and none of them hits a flag, it ends with `noMatch`=1 and `lenOut`=ADDR_W.
- R6: If a computed child address is greater than the highest node address written since reset, the walk ends with `errOut`=1. In that case `lenOut` counts the bits consumed, including those of the current node.
- R7: Each node visit takes two cycles. `done` rises exactly 2·N clock edges after the `start` edge, where N is the number of nodes visited. `done` lasts one cycle, and `busy` is high from the edge after `start` until that edge.
- R8: A `start` pulse that arrives while `busy` is high is ignored. The running walk finishes with the result for its own address.
- R9: `keyOut`, `lenOut` and the three outcome flags hold their values until the next `done`. Exactly one outcome flag is high whenever `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Node memory write enable |
| wrAddr | input | NODE_AW | Node memory write address |
| wrData | input | OFF_W+2^STRIDE | Node word: offset above flag bitmap |
| start | input | 1 | Begin a lookup of `addrIn` |
| addrIn | input | ADDR_W | Address to look up |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion strobe |
| matchOut | output | 1 | Walk ended on a set flag |
| noMatch | output | 1 | Address exhausted with no set flag |
| errOut | output | 1 | Child address beyond loaded nodes |
| keyOut | output | ADDR_W | Consumed address bits, left-aligned |
| lenOut | output | $clog2(ADDR_W+1) | Number of consumed bits |

## Verification
The hardest situation to reach from the ports is a walk that uses up every stride without hitting a set flag. A correctly built trie never does this. The stimulus therefore loads a node whose offset and zero count lead straight back to itself, and then sends an address that selects that index at every level. The error path is reached by first loading a node whose child lies beyond the highest written address, then writing that child later and checking that the same address now matches. A second `start` is also sent in the middle of a walk to show that it is ignored.

// File: rtl/oet_pkg.sv
package oet_pkg;

  typedef enum logic [1:0] {
    OUT_MATCH = 2'd0,
    OUT_NONE  = 2'd1,
    OUT_ERR   = 2'd2
  } outcome_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_EVAL  = 2'd2
  } walk_state_e;

  typedef struct packed {
    logic     load;
    logic     fetch;
    logic     advance;
    logic     finish;
    outcome_e kind;
  } walk_cmd_t;

endpackage

// File: rtl/oet_ctrl.sv
module oet_ctrl
  import oet_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      flagHit,
  input  logic      lastLevel,
  input  logic      childBad,
  output walk_cmd_t cmd,
  output logic      busy
);

  walk_state_e state, stateNext;

  always_comb begin
    cmd       = '0;
    cmd.kind  = OUT_MATCH;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          cmd.load  = 1'b1;
          stateNext = ST_FETCH;
        end
      end
      ST_FETCH: begin
        cmd.fetch = 1'b1;
        stateNext = ST_EVAL;
      end
      ST_EVAL: begin
        if (flagHit) begin
          cmd.finish = 1'b1;
          cmd.kind   = OUT_MATCH;
          stateNext  = ST_IDLE;
        end else if (lastLevel) begin
          cmd.finish = 1'b1;
          cmd.kind   = OUT_NONE;
          stateNext  = ST_IDLE;
        end else if (childBad) begin
          cmd.finish = 1'b1;
          cmd.kind   = OUT_ERR;
          stateNext  = ST_IDLE;
        end else begin
          cmd.advance = 1'b1;
          stateNext   = ST_FETCH;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/oet_dp.sv
module oet_dp
  import oet_pkg::*;
#(
  parameter int STRIDE  = 2,
  parameter int ADDR_W  = 16,
  parameter int NODE_AW = 6,
  parameter int OFF_W   = 4,
  localparam int FLAG_W = 1 << STRIDE,
  localparam int WORD_W = OFF_W + FLAG_W,
  localparam int LEN_W  = $clog2(ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  walk_cmd_t         cmd,
  input  logic              wrEn,
  input  logic [NODE_AW-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [ADDR_W-1:0] addrIn,
  output logic              flagHit,
  output logic              lastLevel,
  output logic              childBad,
  output logic              done,
  output logic              matchOut,
  output logic              noMatch,
  output logic              errOut,
  output logic [ADDR_W-1:0] keyOut,
  output logic [LEN_W-1:0]  lenOut
);

  localparam int DEPTH  = 1 << NODE_AW;
  localparam int LEVELS = ADDR_W / STRIDE;
  localparam int LVL_W  = $clog2(LEVELS + 1);
  localparam int CNT_W  = $clog2(FLAG_W + 1);
  localparam int CH_W   = ((NODE_AW > OFF_W) ? NODE_AW : OFF_W) + 2;

  logic [WORD_W-1:0]  nodeMem [DEPTH];
  logic [WORD_W-1:0]  rdWord;
  logic [NODE_AW-1:0] topAddr;
  logic [NODE_AW-1:0] curAddr;
  logic [ADDR_W-1:0]  addrReg;
  logic [ADDR_W-1:0]  remAddr;
  logic [LVL_W-1:0]   level;

  logic [FLAG_W-1:0]  flags;
  logic [OFF_W-1:0]   offset;
  logic [STRIDE-1:0]  idx;
  logic [CNT_W-1:0]   zeroBelow;
  logic [CH_W-1:0]    childAddr;
  logic [LEN_W-1:0]   lenNext;
  logic [ADDR_W-1:0]  keyMask;

  // node memory with highest-written tracking
  always_ff @(posedge clk) begin
    if (wrEn) nodeMem[wrAddr] <= wrData;
    if (cmd.fetch) rdWord <= nodeMem[curAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) topAddr <= '0;
    else if (wrEn && (wrAddr > topAddr)) topAddr <= wrAddr;
  end

  assign flags  = rdWord[FLAG_W-1:0];
  assign offset = rdWord[WORD_W-1:FLAG_W];
  assign idx    = remAddr[ADDR_W-1 -: STRIDE];

  // zero flags strictly below the selected index
  always_comb begin
    zeroBelow = '0;
    for (int b = 0; b < FLAG_W; b++) begin
      if ((b < int'(idx)) && !flags[b]) zeroBelow = zeroBelow + 1'b1;
    end
  end

  assign childAddr = CH_W'(curAddr) + CH_W'(offset) + CH_W'(zeroBelow);
  assign flagHit   = flags[idx];
  assign lastLevel = (level == LVL_W'(LEVELS - 1));
  assign childBad  = (childAddr > CH_W'(topAddr));

  always_comb begin
    int consumed;
    consumed = (int'(level) + 1) * STRIDE;
    lenNext  = LEN_W'(consumed);
    keyMask  = ~({ADDR_W{1'b1}} >> lenNext);
  end

  // walk registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      addrReg <= '0;
      remAddr <= '0;
      level   <= '0;
    end else if (cmd.load) begin
      curAddr <= NODE_AW'(1);
      addrReg <= addrIn;
      remAddr <= addrIn;
      level   <= '0;
    end else if (cmd.advance) begin
      curAddr <= childAddr[NODE_AW-1:0];
      remAddr <= remAddr << STRIDE;
      level   <= level + 1'b1;
    end
  end

  // result registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      done     <= 1'b0;
      matchOut <= 1'b0;
      noMatch  <= 1'b0;
      errOut   <= 1'b0;
      keyOut   <= '0;
      lenOut   <= '0;
    end else begin
      done <= cmd.finish;
      if (cmd.finish) begin
        matchOut <= (cmd.kind == OUT_MATCH);
        noMatch  <= (cmd.kind == OUT_NONE);
        errOut   <= (cmd.kind == OUT_ERR);
        keyOut   <= addrReg & keyMask;
        lenOut   <= lenNext;
      end
    end
  end

endmodule

// File: rtl/oet_lookup.sv
module oet_lookup
  import oet_pkg::*;
#(
  parameter int STRIDE  = 2,
  parameter int ADDR_W  = 16,
  parameter int NODE_AW = 6,
  parameter int OFF_W   = 4,
  localparam int WORD_W = OFF_W + (1 << STRIDE),
  localparam int LEN_W  = $clog2(ADDR_W + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [NODE_AW-1:0] wrAddr,
  input  logic [WORD_W-1:0]  wrData,
  input  logic               start,
  input  logic [ADDR_W-1:0]  addrIn,
  output logic               busy,
  output logic               done,
  output logic               matchOut,
  output logic               noMatch,
  output logic               errOut,
  output logic [ADDR_W-1:0]  keyOut,
  output logic [LEN_W-1:0]   lenOut
);

  walk_cmd_t cmd;
  logic      flagHit;
  logic      lastLevel;
  logic      childBad;

  oet_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .flagHit   (flagHit),
    .lastLevel (lastLevel),
    .childBad  (childBad),
    .cmd       (cmd),
    .busy      (busy)
  );

  oet_dp #(
    .STRIDE  (STRIDE),
    .ADDR_W  (ADDR_W),
    .NODE_AW (NODE_AW),
    .OFF_W   (OFF_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .addrIn    (addrIn),
    .flagHit   (flagHit),
    .lastLevel (lastLevel),
    .childBad  (childBad),
    .done      (done),
    .matchOut  (matchOut),
    .noMatch   (noMatch),
    .errOut    (errOut),
    .keyOut    (keyOut),
    .lenOut    (lenOut)
  );

endmodule

// File: rtl/oet_lookup_chk.sv
module oet_lookup_chk #(
  parameter int STRIDE = 2,
  parameter int ADDR_W = 16,
  localparam int LEN_W = $clog2(ADDR_W + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              matchOut,
  input logic              noMatch,
  input logic              errOut,
  input logic [ADDR_W-1:0] keyOut,
  input logic [LEN_W-1:0]  lenOut
);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  a_r7_start_takes: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  a_r8_busy_origin: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $onehot({matchOut, noMatch, errOut}));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(keyOut) && $stable(lenOut) && $stable(matchOut)));

  a_r3_len_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    (done && matchOut) |-> (lenOut != '0 && (int'(lenOut) % STRIDE) == 0));

endmodule

bind oet_lookup oet_lookup_chk #(
  .STRIDE (STRIDE),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .matchOut (matchOut),
  .noMatch  (noMatch),
  .errOut   (errOut),
  .keyOut   (keyOut),
  .lenOut   (lenOut)
);

// File: tb/test_oet_lookup.sv
module test_oet_lookup;

  localparam int STRIDE  = 2;
  localparam int ADDR_W  = 16;
  localparam int NODE_AW = 6;
  localparam int OFF_W   = 4;
  localparam int FLAG_W  = 1 << STRIDE;
  localparam int WORD_W  = OFF_W + FLAG_W;
  localparam int LEN_W   = $clog2(ADDR_W + 1);
  localparam int LEVELS  = ADDR_W / STRIDE;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               wrEn = 1'b0;
  logic [NODE_AW-1:0] wrAddr = '0;
  logic [WORD_W-1:0]  wrData = '0;
  logic               start = 1'b0;
  logic [ADDR_W-1:0]  addrIn = '0;
  logic               busy, done, matchOut, noMatch, errOut;
  logic [ADDR_W-1:0]  keyOut;
  logic [LEN_W-1:0]   lenOut;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  int refFlags [64];
  int refOff   [64];
  int refTop   = 0;

  always #5 clk = ~clk;

  oet_lookup #(
    .STRIDE(STRIDE), .ADDR_W(ADDR_W), .NODE_AW(NODE_AW), .OFF_W(OFF_W)
  ) i_oet_lookup (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .start(start), .addrIn(addrIn), .busy(busy), .done(done),
    .matchOut(matchOut), .noMatch(noMatch), .errOut(errOut),
    .keyOut(keyOut), .lenOut(lenOut)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic writeNode(input int a, input int fl, input int off);
    @(negedge clk);
    wrEn = 1'b1;
    wrAddr = NODE_AW'(a);
    wrData = {OFF_W'(off), FLAG_W'(fl)};
    refFlags[a] = fl;
    refOff[a] = off;
    if (a > refTop) refTop = a;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // behavioural walk: kind 0 match, 1 none, 2 error
  task automatic model(input int a, output int kind, output int nodes);
    int cur = 1;
    kind = 1;
    nodes = 0;
    for (int lv = 0; lv < LEVELS; lv++) begin
      int ix = (a >> (ADDR_W - STRIDE * (lv + 1))) & (FLAG_W - 1);
      int z = 0;
      nodes = lv + 1;
      if ((refFlags[cur] >> ix) & 1) begin kind = 0; return; end
      if (lv == LEVELS - 1) begin kind = 1; return; end
      for (int b = 0; b < ix; b++) if (((refFlags[cur] >> b) & 1) == 0) z++;
      cur = cur + refOff[cur] + z;
      if (cur > refTop) begin kind = 2; return; end
    end
  endtask

  task automatic lookup(input int a, input string req, input bit poke);
    int kind, nodes, expLen, expKey;
    bit timingOk = 1;
    model(a, kind, nodes);
    expLen = nodes * STRIDE;
    expKey = (expLen == 0) ? 0 : (a & ~((1 << (ADDR_W - expLen)) - 1)) & 16'hFFFF;
    @(negedge clk);
    start = 1'b1;
    addrIn = ADDR_W'(a);
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= 2 * nodes; k++) begin
      if (k > 1) @(negedge clk);
      if (poke && k == 2) begin start = 1'b1; addrIn = ~ADDR_W'(a); end
      if (poke && k == 3) start = 1'b0;
      if (k < 2 * nodes && (!busy || done)) timingOk = 0;
    end
    @(negedge clk);
    start = 1'b0;
    check(timingOk && done && !busy, "R7", "done timing", done, 1);
    check(matchOut == (kind == 0), req, "match flag", matchOut, kind == 0);
    check(noMatch == (kind == 1), "R5", "no-match flag", noMatch, kind == 1);
    check(errOut == (kind == 2), "R6", "error flag", errOut, kind == 2);
    check(int'(lenOut) == expLen, req, "length", lenOut, expLen);
    check(int'(keyOut) == expKey, req, "key", keyOut, expKey);
    @(negedge clk);
    check(!done && int'(keyOut) == expKey && int'(lenOut) == expLen, "R9",
          "hold after done", keyOut, expKey);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin refFlags[i] = 0; refOff[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !done && !matchOut && !noMatch && !errOut, "R1",
          "reset flags", {busy, done, matchOut, noMatch, errOut}, 0);
    check(keyOut == '0 && lenOut == '0, "R1", "reset key", keyOut, 0);
    rstN = 1'b1;
    // R2 layout: root 1 flags 0100, children at 2,3,4
    writeNode(1, 4'b0100, 1);
    writeNode(2, 4'b1111, 0);
    writeNode(3, 4'b1110, 2);
    writeNode(4, 4'b0000, 1);
    writeNode(5, 4'b1000, 0);
    writeNode(6, 4'b1111, 0);
    lookup(16'h8000, "R3", 0);   // root hit, len 2
    lookup(16'h9ABC, "R3", 0);   // key masking
    lookup(16'h0000, "R2", 0);   // root idx0 -> node 2
    lookup(16'h5000, "R4", 0);   // zero count 1 -> node 3
    lookup(16'hD800, "R4", 0);   // node 4 idx1 -> node 6
    lookup(16'h4000, "R5", 0);   // self loop at node 5 to exhaustion
    lookup(16'hF000, "R6", 0);   // node 4 idx3 -> 8 beyond top 6
    lookup(16'h5000, "R8", 1);   // second start during walk ignored
    writeNode(8, 4'b1111, 0);
    lookup(16'hF000, "R6", 0);   // now loaded, matches at level 3
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule